// File: doc/BRIEF.md
# Majority-Clocked Three-Register Keystream Generator

This block produces the keystream for one radio frame of a GSM-style stream cipher. A single-cycle start strobe captures a 64-bit session key and a 22-bit frame number. Three linear feedback shift registers of 19, 22 and 23 bits are cleared, and the captured key and then the frame number are folded into them one bit per cycle. After that, the registers are clocked irregularly by a majority vote over one clocking bit per register.

After the load phases and 100 discarded mixing steps, the block delivers 228 keystream bits on a serial output, one per cycle, with a valid flag. The first 114 bits serve one link direction and the last 114 serve the other. A one-cycle done flag marks the end of the frame. The caller combines the keystream with data elsewhere.

Top module: `keystream_gen`

## Requirements
- R1: After synchronous active-low reset, `ks_valid`, `ks_done` and `ks_bit` are 0, and no output appears until a start strobe is accepted.
- R2: On an accepted start, all three registers are cleared. For the next 64 cycles, every register steps on every cycle, shifting toward its MSB, with `key[0]` first. Each new bit 0 is the XOR of the register's taps and the current key bit. The taps are bits 13, 16, 17 and 18 of the 19-bit register, bits 20 and 21 of the 22-bit register, and bits 7, 20, 21 and 22 of the 23-bit register.
- R3: For the 22 cycles after the key phase, every register steps on every cycle with the same feedback, XORing in `frame_no[0]` first.
- R4: In the mixing and output phases, the clocking bits are bit 8 of the 19-bit register and bit 10 of the other two. A register steps only when its clocking bit equals the majority of the three, so at least two registers step on every such cycle.
- R5: 100 majority-clocked steps follow the frame phase and produce no output. The first valid bit appears 187 clock edges after the edge that accepts the start.
- R6: The block runs 228 further majority-clocked steps. Each one yields `ks_bit`, the XOR of the three register MSBs after that step, presented in the cycle after the step.
- R7: `ks_valid` is high for exactly 228 consecutive cycles per frame and never together with `ks_done`.
- R8: `ks_done` is high for exactly one cycle, the cycle directly after the last valid bit.
- R9: A start strobe while a frame is in progress is ignored: no restart, no extra bits, no extra done.
- R10: `key` and `frame_no` are captured when the start is accepted. Changing them later in the frame has no effect on the keystream.
- R11: Each frame starts from cleared registers, so the same key and frame number always give the same 228 bits, regardless of earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start-of-frame strobe, accepted only when idle |
| key | input | 64 | Session key, bit 0 loaded first |
| frame_no | input | 22 | Frame number, bit 0 loaded first |
| ks_bit | output | 1 | Serial keystream bit |
| ks_valid | output | 1 | High while `ks_bit` carries keystream |
| ks_done | output | 1 | One-cycle pulse after the last keystream bit |

## Verification
The bench holds its own bit-level model of the three registers and compares all 228 bits of several frames. Two of those frames make the corner cases visible: an all-zero key and frame, where a wrong feedback seed breaks the all-zero stream, and an all-ones key and frame, where every tap contributes.

A wrong tap, clocking bit, load order or majority polarity shows up as a mismatching bit. An off-by-one in any phase length moves the first valid bit away from 187 edges or changes the count of 228. A frame restarted by a second start, or one that follows inputs changed mid-run, produces a stream from the wrong key with a late done. Replaying an earlier frame after others exposes registers that are not cleared.

// File: rtl/ks_pkg.sv
// Package: shared constants, phase type and per-register geometry for the
// keystream generator. Assumes exactly three registers in the lane tables.
package ks_pkg;

    localparam int NUM_LANES  = 3;
    localparam int KEY_BITS   = 64;
    localparam int FRAME_BITS = 22;
    localparam int MIX_STEPS  = 100;
    localparam int OUT_STEPS  = 228;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_KEY   = 3'd1,
        PH_FRAME = 3'd2,
        PH_MIX   = 3'd3,
        PH_OUT   = 3'd4,
        PH_DONE  = 3'd5
    } phase_t;

    // Length of register lane i
    function automatic int lane_width(input int i);
        case (i)
            0:       return 19;
            1:       return 22;
            default: return 23;
        endcase
    endfunction

    // Feedback tap mask of register lane i (bit k set = bit k tapped)
    function automatic logic [31:0] lane_taps(input int i);
        case (i)
            0:       return (32'd1 << 13) | (32'd1 << 16) | (32'd1 << 17) | (32'd1 << 18);
            1:       return (32'd1 << 20) | (32'd1 << 21);
            default: return (32'd1 << 7) | (32'd1 << 20) | (32'd1 << 21) | (32'd1 << 22);
        endcase
    endfunction

    // Clocking-bit position of register lane i
    function automatic int lane_clk_bit(input int i);
        case (i)
            0:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/ks_lfsr.sv
// Module: one Fibonacci shift register lane. Shifts toward the MSB and enters
// the XOR of its taps and an injected bit at bit 0 when stepped.
// Assumes WIDTH >= 2 and tap/clock positions below WIDTH.
module ks_lfsr #(
    parameter int          WIDTH   = 19,
    parameter logic [31:0] TAPS    = 32'h0007_2000,
    parameter int          CLK_BIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic inject,
    output logic clk_tap,
    output logic msb_next
);

    localparam logic [WIDTH-1:0] TAP_MASK = TAPS[WIDTH-1:0];

    logic [WIDTH-1:0] state;
    logic             fb;

    // Feedback bit: parity of tapped bits plus injected load bit
    always_comb fb = (^(state & TAP_MASK)) ^ inject;

    // State register: clear on frame start, shift when stepped
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state <= '0;
        end else if (step) begin
            state <= {state[WIDTH-2:0], fb};
        end
    end

    // Taps seen by the vote and the MSB the register will hold after this cycle
    always_comb begin
        clk_tap  = state[CLK_BIT];
        msb_next = step ? state[WIDTH-2] : state[WIDTH-1];
    end

endmodule

// File: rtl/ks_majority.sv
// Module: majority vote over N clocking bits; flags every lane that agrees
// with the majority. Assumes N is odd so no tie can occur.
module ks_majority #(
    parameter int N = 3
) (
    input  logic [N-1:0] votes,
    output logic [N-1:0] agree
);

    logic maj;

    // Majority value of the votes
    always_comb maj = ($countones(votes) > (N / 2));

    for (genvar g = 0; g < N; g++) begin : g_agree
        // Lane g steps when its vote matches the majority
        always_comb agree[g] = (votes[g] == maj);
    end

endmodule

// File: rtl/ks_sequencer.sv
// Module: phase sequencer. Accepts a start only when idle, then walks key,
// frame, mix and output phases of fixed lengths and one done cycle.
// Assumes every phase length fits in the counter width.
module ks_sequencer #(
    parameter int KEY_LEN   = 64,
    parameter int FRAME_LEN = 22,
    parameter int MIX_LEN   = 100,
    parameter int OUT_LEN   = 228
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output ks_pkg::phase_t phase,
    output logic           accept
);
    import ks_pkg::*;

    localparam int MAX_LEN = (OUT_LEN > MIX_LEN) ? OUT_LEN : MIX_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    phase_t           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last;

    // Counter reaches the final cycle of the current phase
    always_comb begin
        case (phase_q)
            PH_KEY:   last = (cnt_q == CNT_W'(KEY_LEN - 1));
            PH_FRAME: last = (cnt_q == CNT_W'(FRAME_LEN - 1));
            PH_MIX:   last = (cnt_q == CNT_W'(MIX_LEN - 1));
            PH_OUT:   last = (cnt_q == CNT_W'(OUT_LEN - 1));
            default:  last = 1'b0;
        endcase
    end

    // Next phase and counter
    always_comb begin
        phase_d = phase_q;
        cnt_d   = last ? '0 : cnt_q + 1'b1;
        accept  = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                cnt_d = '0;
                if (start) begin
                    phase_d = PH_KEY;
                    accept  = 1'b1;
                end
            end
            PH_KEY:   if (last) phase_d = PH_FRAME;
            PH_FRAME: if (last) phase_d = PH_MIX;
            PH_MIX:   if (last) phase_d = PH_OUT;
            PH_OUT:   if (last) phase_d = PH_DONE;
            default: begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Phase and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb phase = phase_q;

endmodule

// File: rtl/keystream_gen.sv
// Module: top of the keystream generator. Captures key and frame number on an
// accepted start, loads them into three register lanes, then clocks the lanes
// by majority and emits 228 keystream bits followed by a done pulse.
// Assumes start is a synchronous strobe; inputs are only sampled at accept.
module keystream_gen #(
    parameter int KEY_W   = ks_pkg::KEY_BITS,
    parameter int FRAME_W = ks_pkg::FRAME_BITS,
    parameter int MIX_LEN = ks_pkg::MIX_STEPS,
    parameter int OUT_LEN = ks_pkg::OUT_STEPS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [KEY_W-1:0]   key,
    input  logic [FRAME_W-1:0] frame_no,
    output logic               ks_bit,
    output logic               ks_valid,
    output logic               ks_done
);
    import ks_pkg::*;

    localparam int N = NUM_LANES;

    phase_t             phase_w;
    logic               accept;
    logic [KEY_W-1:0]   key_sr;
    logic [FRAME_W-1:0] frame_sr;
    logic               inject;
    logic [N-1:0]       votes, agree, step_en, msb_next;

    ks_sequencer #(
        .KEY_LEN   (KEY_W),
        .FRAME_LEN (FRAME_W),
        .MIX_LEN   (MIX_LEN),
        .OUT_LEN   (OUT_LEN)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .phase  (phase_w),
        .accept (accept)
    );

    // Load shift registers: capture inputs at accept, drain LSB first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_sr   <= '0;
            frame_sr <= '0;
        end else if (accept) begin
            key_sr   <= key;
            frame_sr <= frame_no;
        end else begin
            if (phase_w == PH_KEY)   key_sr   <= key_sr >> 1;
            if (phase_w == PH_FRAME) frame_sr <= frame_sr >> 1;
        end
    end

    // Bit folded into every lane's feedback during load phases
    always_comb begin
        case (phase_w)
            PH_KEY:   inject = key_sr[0];
            PH_FRAME: inject = frame_sr[0];
            default:  inject = 1'b0;
        endcase
    end

    ks_majority #(.N(N)) u_maj (
        .votes (votes),
        .agree (agree)
    );

    // Step enables: all lanes during load, majority-agreeing lanes afterwards
    always_comb begin
        case (phase_w)
            PH_KEY, PH_FRAME: step_en = '1;
            PH_MIX, PH_OUT:   step_en = agree;
            default:          step_en = '0;
        endcase
    end

    for (genvar g = 0; g < N; g++) begin : g_lane
        localparam int          LW  = lane_width(g);
        localparam logic [31:0] LT  = lane_taps(g);
        localparam int          LCB = lane_clk_bit(g);
        ks_lfsr #(
            .WIDTH   (LW),
            .TAPS    (LT),
            .CLK_BIT (LCB)
        ) u_lfsr (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (accept),
            .step     (step_en[g]),
            .inject   (inject),
            .clk_tap  (votes[g]),
            .msb_next (msb_next[g])
        );
    end

    // Output registers: keystream bit, valid window and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ks_bit   <= 1'b0;
            ks_valid <= 1'b0;
            ks_done  <= 1'b0;
        end else begin
            ks_valid <= (phase_w == PH_OUT);
            ks_bit   <= (phase_w == PH_OUT) ? ^msb_next : 1'b0;
            ks_done  <= (phase_w == PH_DONE);
        end
    end

endmodule

// File: rtl/ks_checker.sv
// Module: protocol and clocking checks for keystream_gen, attached by bind.
// Assumes it observes the top's outputs, phase and lane step enables.
module ks_checker #(
    parameter int N = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ks_valid,
    input logic           ks_done,
    input ks_pkg::phase_t phase,
    input logic [N-1:0]   step_en
);
    import ks_pkg::*;

    // R4: majority clocking always steps at least two lanes
    a_r4_two_lanes_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MIX || phase == PH_OUT) |-> ($countones(step_en) >= 2));

    // R7: valid and done never overlap
    a_r7_valid_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ks_valid && ks_done));

    // R8: done lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        ks_done |=> !ks_done);

    // R8: end of the valid window coincides with done
    a_r8_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ks_valid) |-> ks_done);

    // R1: no keystream while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !ks_valid);

endmodule

bind keystream_gen ks_checker #(.N(ks_pkg::NUM_LANES)) u_ks_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ks_valid (ks_valid),
    .ks_done  (ks_done),
    .phase    (phase_w),
    .step_en  (step_en)
);

// File: tb/tb_keystream_gen.sv
module tb_keystream_gen;

    localparam int CLK_PERIOD = 10;
    localparam int OUT_N      = 228;
    localparam int LATENCY    = 187;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] key = '0;
    logic [21:0] frame_no = '0;
    logic        ks_bit, ks_valid, ks_done;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc = 0;
    int start_cyc = 0;
    int first_lat = -1;
    int valid_cnt = 0;
    int done_cnt  = 0;
    bit seen_first = 1'b0;
    bit prev_valid = 1'b0;
    bit exp_q[$];

    keystream_gen dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .key      (key),
        .frame_no (frame_no),
        .ks_bit   (ks_bit),
        .ks_valid (ks_valid),
        .ks_done  (ks_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Independent reference: 228 keystream bits for key k and frame f
    function automatic logic [OUT_N-1:0] ref_stream(input logic [63:0] k,
                                                    input logic [21:0] f);
        logic [18:0] a = '0;
        logic [21:0] b = '0;
        logic [22:0] c = '0;
        logic [OUT_N-1:0] s = '0;
        logic m, fa, fb, fc;
        for (int i = 0; i < 86; i++) begin
            logic x;
            x  = (i < 64) ? k[i] : f[i-64];
            fa = a[13] ^ a[16] ^ a[17] ^ a[18] ^ x;
            fb = b[20] ^ b[21] ^ x;
            fc = c[7] ^ c[20] ^ c[21] ^ c[22] ^ x;
            a = {a[17:0], fa};
            b = {b[20:0], fb};
            c = {c[21:0], fc};
        end
        for (int i = 0; i < 100 + OUT_N; i++) begin
            m  = (a[8] & b[10]) | (a[8] & c[10]) | (b[10] & c[10]);
            fa = a[13] ^ a[16] ^ a[17] ^ a[18];
            fb = b[20] ^ b[21];
            fc = c[7] ^ c[20] ^ c[21] ^ c[22];
            if (a[8] == m)  a = {a[17:0], fa};
            if (b[10] == m) b = {b[20:0], fb};
            if (c[10] == m) c = {c[21:0], fc};
            if (i >= 100) s[i-100] = a[18] ^ b[21] ^ c[22];
        end
        return s;
    endfunction

    // Monitor: pops expected bits and checks valid/done protocol
    always @(negedge clk) begin
        if (rst_n) begin
            if (ks_valid) begin
                bit e;
                if (!seen_first) begin
                    seen_first = 1'b1;
                    first_lat  = cyc - start_cyc;
                end
                valid_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected keystream bit", ks_bit, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(ks_bit == e, "R6", "keystream bit", ks_bit, e);
                end
            end
            if (ks_done) begin
                done_cnt++;
                check(prev_valid && !ks_valid, "R8", "done right after last valid",
                      prev_valid, 1);
            end
            prev_valid = ks_valid;
        end
    end

    // Driver: queue expected stream, strobe start, optionally disturb mid-frame
    task automatic run_frame(input logic [63:0] k, input logic [21:0] f,
                             input bit disturb, input string tag);
        logic [OUT_N-1:0] s;
        s = ref_stream(k, f);
        for (int i = 0; i < OUT_N; i++) exp_q.push_back(s[i]);
        valid_cnt  = 0;
        done_cnt   = 0;
        seen_first = 1'b0;
        first_lat  = -1;
        @(negedge clk);
        key       = k;
        frame_no  = f;
        start     = 1'b1;
        start_cyc = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (50) @(negedge clk);
            // R9, R10: second start and new inputs while busy
            key      = ~k;
            frame_no = ~f;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (250) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        repeat (430) @(negedge clk);
        check(valid_cnt == OUT_N, "R7", {tag, " valid cycles"}, valid_cnt, OUT_N);
        check(done_cnt == 1, "R8", {tag, " done pulses"}, done_cnt, 1);
        check(first_lat == LATENCY, "R5", {tag, " first-bit latency"}, first_lat, LATENCY);
        check(exp_q.size() == 0, "R6", {tag, " bits left unmatched"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "ALL", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ks_valid == 1'b0, "R1", "valid after reset", ks_valid, 0);
        check(ks_done == 1'b0, "R1", "done after reset", ks_done, 0);
        check(ks_bit == 1'b0, "R1", "bit after reset", ks_bit, 0);
        repeat (20) @(negedge clk);
        check(valid_cnt == 0 && done_cnt == 0, "R1", "idle output without start",
              valid_cnt + done_cnt, 0);

        // R2, R3, R4, R6: typical key and frame
        run_frame(64'h0123_4567_89AB_CDEF, 22'h000134, 1'b0, "frameA");
        // R2, R3: all-zero load must give an all-zero stream
        run_frame(64'h0, 22'h0, 1'b0, "zeros");
        // R2, R3, R4: all taps and clocking bits driven by ones
        run_frame({64{1'b1}}, {22{1'b1}}, 1'b0, "ones");
        // R9, R10: start and input changes while busy
        run_frame(64'hDEAD_BEEF_0BAD_F00D, 22'h2A5A5A, 1'b1, "busy");
        // R11: replay after other frames gives the same stream
        run_frame(64'h0123_4567_89AB_CDEF, 22'h000134, 1'b0, "replayA");
        // R3: frame number alone changes the stream
        run_frame(64'h0123_4567_89AB_CDEF, 22'h000135, 1'b0, "frameB");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule